// File: doc/BRIEF.md
# Interrupt Pending-State Return Controller

This block keeps the pending/active state of a core's event service levels in one register of `NLEV` bits, where bit `GDIS_IDX` (4 by default) is the global interrupt-disable bit. A lower bit index is a higher priority. When the sequencer enters an event, it pulses the entry strobe with the level number. The block then marks that level active and sets global disable in the same clock edge.

When a return instruction retires, the sequencer pulses the return strobe with the kind of return. The interrupt-class return is the only one that depends on configuration. If self-nesting is enabled and the saved nesting flag is 1, the return only drops global disable and the serviced level stays active. The saved nesting flag is the least significant bit of the interrupt return address. In every other case, the interrupt return drops global disable and the bit of the current interrupt level. The other three return kinds always clear the lowest set bit of the whole register.

The self-nesting enable is expected to be written once after reset and then held constant. Arbitration of new requests, pipeline aborts and stacking of return addresses belong to neighbouring blocks.

Top module: `pend_return_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the register to all zeros and drives `ret_err` low.
- R2: An entry strobe sets the register bit selected by `enter_lvl` and sets bit 4 (global disable), both visible after the same clock edge.
- R3: An interrupt return (`ret_kind` = 0) with `nest_en` = 1 and `ret_addr_lsb` = 1 clears bit 4 only and leaves every other bit unchanged.
- R4: An interrupt return with `nest_en` = 0, or with `ret_addr_lsb` = 0, clears bit 4 and the bit of the current interrupt level. If no bit at index 5 or above is set, it clears bit 4 only.
- R5: An exception return (`ret_kind` = 1), a non-maskable return (`ret_kind` = 2) and an emulation return (`ret_kind` = 3) each clear the least significant set bit of the whole register, at any index.
- R6: When a return strobe and an entry strobe arrive in the same cycle, the return is applied first and the entry is then applied to its result.
- R7: A return strobe while the register is all zeros changes nothing through the return. `ret_err` is high for exactly the one cycle after that strobe and low otherwise.
- R8: `cur_lvl` gives the index of the lowest set bit at index 5 or above, and `cur_vld` is high exactly when such a bit exists. When `cur_vld` is low, `cur_lvl` is 0.
- R9: `gdis` always equals bit 4 of the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enter_vld | input | 1 | Event entry strobe |
| enter_lvl | input | 4 | Level being entered |
| ret_vld | input | 1 | Return instruction retired |
| ret_kind | input | 2 | 0 interrupt, 1 exception, 2 non-maskable, 3 emulation |
| nest_en | input | 1 | Self-nesting enable |
| ret_addr_lsb | input | 1 | Saved nesting flag (low bit of the interrupt return address) |
| pend_q | output | 16 | Pending/active register |
| cur_lvl | output | 4 | Current interrupt level |
| cur_vld | output | 1 | A level at index 5 or above is active |
| gdis | output | 1 | Global interrupt disable |
| ret_err | output | 1 | Return with an empty register, one cycle late |

## Verification
The hardest case to reach is a return that coincides with an entry. This matters most when the entry re-sets the very bit the return clears, because the register then looks untouched. The bench builds a nested stack of levels with a chain of entries, then issues combined return-and-entry cycles of each kind. It also drains the register to zero with exception-class returns so that a return on an empty register, with and without a coincident entry, can be issued.

// File: rtl/pend_ret_pkg.sv
package pend_ret_pkg;
   typedef enum logic [1:0] {
      RK_INT  = 2'd0,
      RK_EXC  = 2'd1,
      RK_NMI  = 2'd2,
      RK_EMU  = 2'd3
   } ret_kind_e;
endpackage

// File: rtl/lsb_scan.sv
module lsb_scan #(
   parameter int W  = 16,
   parameter int LO = 0,
   localparam int IW = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [IW-1:0] idx,
   output logic          hit
);
   generate
      if (LO >= W) begin : g_bad
         $error("lsb_scan: LO must be below W");
      end
   endgenerate

   always_comb begin
      hit = 1'b0;
      idx = '0;
      for (int i = W - 1; i >= LO; i--) begin
         if (vec[i]) begin
            hit = 1'b1;
            idx = IW'(i);
         end
      end
   end
endmodule

// File: rtl/pend_next.sv
module pend_next
   import pend_ret_pkg::*;
#(
   parameter int NLEV     = 16,
   parameter int GDIS_IDX = 4,
   localparam int LW      = $clog2(NLEV)
) (
   input  logic [NLEV-1:0] cur,
   input  logic            ret_vld,
   input  logic [1:0]      ret_kind,
   input  logic            nest_en,
   input  logic            ret_addr_lsb,
   input  logic            enter_vld,
   input  logic [LW-1:0]   enter_lvl,
   input  logic [LW-1:0]   low_idx,
   input  logic            low_hit,
   input  logic [LW-1:0]   lvl_idx,
   input  logic            lvl_hit,
   output logic [NLEV-1:0] nxt,
   output logic            empty_ret
);
   logic [NLEV-1:0] after_ret;
   logic [NLEV-1:0] clr_mask;
   logic [NLEV-1:0] set_mask;
   ret_kind_e       kind;

   assign kind      = ret_kind_e'(ret_kind);
   assign empty_ret = ret_vld && (cur == '0);

   always_comb begin
      clr_mask = '0;
      if (ret_vld && !empty_ret) begin
         if (kind == RK_INT) begin
            clr_mask[GDIS_IDX] = 1'b1;
            if (!(nest_en && ret_addr_lsb) && lvl_hit) begin
               for (int b = 0; b < NLEV; b++)
                  if (LW'(b) == lvl_idx) clr_mask[b] = 1'b1;
            end
         end else if (low_hit) begin
            for (int b = 0; b < NLEV; b++)
               if (LW'(b) == low_idx) clr_mask[b] = 1'b1;
         end
      end
   end

   always_comb begin
      set_mask = '0;
      if (enter_vld) begin
         set_mask[GDIS_IDX] = 1'b1;
         for (int b = 0; b < NLEV; b++)
            if (LW'(b) == enter_lvl) set_mask[b] = 1'b1;
      end
   end

   assign after_ret = cur & ~clr_mask;
   assign nxt       = after_ret | set_mask;
endmodule

// File: rtl/pend_return_ctrl.sv
module pend_return_ctrl #(
   parameter int NLEV     = 16,
   parameter int GDIS_IDX = 4,
   localparam int LW      = $clog2(NLEV)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            enter_vld,
   input  logic [LW-1:0]   enter_lvl,
   input  logic            ret_vld,
   input  logic [1:0]      ret_kind,
   input  logic            nest_en,
   input  logic            ret_addr_lsb,
   output logic [NLEV-1:0] pend_q,
   output logic [LW-1:0]   cur_lvl,
   output logic            cur_vld,
   output logic            gdis,
   output logic            ret_err
);
   generate
      if (GDIS_IDX + 1 >= NLEV) begin : g_bad_gdis
         $error("pend_return_ctrl: no interrupt levels above the disable bit");
      end
      if ((1 << LW) != NLEV) begin : g_bad_nlev
         $error("pend_return_ctrl: NLEV must be a power of two");
      end
   endgenerate

   logic [NLEV-1:0] nxt;
   logic [LW-1:0]   low_idx;
   logic            low_hit;
   logic            empty_ret;

   lsb_scan #(.W(NLEV), .LO(0)) u_low_scan (
      .vec (pend_q),
      .idx (low_idx),
      .hit (low_hit)
   );

   lsb_scan #(.W(NLEV), .LO(GDIS_IDX + 1)) u_lvl_scan (
      .vec (pend_q),
      .idx (cur_lvl),
      .hit (cur_vld)
   );

   pend_next #(.NLEV(NLEV), .GDIS_IDX(GDIS_IDX)) u_next (
      .cur          (pend_q),
      .ret_vld      (ret_vld),
      .ret_kind     (ret_kind),
      .nest_en      (nest_en),
      .ret_addr_lsb (ret_addr_lsb),
      .enter_vld    (enter_vld),
      .enter_lvl    (enter_lvl),
      .low_idx      (low_idx),
      .low_hit      (low_hit),
      .lvl_idx      (cur_lvl),
      .lvl_hit      (cur_vld),
      .nxt          (nxt),
      .empty_ret    (empty_ret)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q  <= '0;
         ret_err <= 1'b0;
      end else begin
         pend_q  <= nxt;
         ret_err <= empty_ret;
      end
   end

   assign gdis = pend_q[GDIS_IDX];
endmodule

// File: rtl/pend_ret_chk.sv
module pend_ret_chk #(
   parameter int NLEV     = 16,
   parameter int GDIS_IDX = 4,
   localparam int LW      = $clog2(NLEV)
) (
   input logic            clk,
   input logic            rst,
   input logic            enter_vld,
   input logic [LW-1:0]   enter_lvl,
   input logic            ret_vld,
   input logic [1:0]      ret_kind,
   input logic            nest_en,
   input logic            ret_addr_lsb,
   input logic [NLEV-1:0] pend_q,
   input logic [LW-1:0]   cur_lvl,
   input logic            cur_vld,
   input logic            gdis,
   input logic            ret_err
);
   logic [NLEV-1:0] gmask;
   assign gmask = NLEV'(1) << GDIS_IDX;

   assert_reset_clears_R1: assert property (@(posedge clk)
      rst |=> (pend_q == '0) && !ret_err);

   assert_entry_sets_R2: assert property (@(posedge clk) disable iff (rst)
      enter_vld |=> pend_q[$past(enter_lvl)] && pend_q[GDIS_IDX]);

   assert_nested_return_R3: assert property (@(posedge clk) disable iff (rst)
      (ret_vld && ret_kind == 2'd0 && nest_en && ret_addr_lsb && !enter_vld && pend_q != '0)
      |=> pend_q == ($past(pend_q) & ~gmask));

   assert_exc_return_R5: assert property (@(posedge clk) disable iff (rst)
      (ret_vld && ret_kind != 2'd0 && !enter_vld && pend_q != '0)
      |=> pend_q == ($past(pend_q) & ($past(pend_q) - NLEV'(1))));

   assert_empty_flag_R7: assert property (@(posedge clk) disable iff (rst)
      (ret_vld && pend_q == '0) |=> ret_err);

   assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
      ret_err |-> $past(ret_vld) && ($past(pend_q) == '0));

   assert_empty_stable_R7: assert property (@(posedge clk) disable iff (rst)
      (ret_vld && pend_q == '0 && !enter_vld) |=> pend_q == '0);

   assert_level_valid_R8: assert property (@(posedge clk) disable iff (rst)
      cur_vld |-> pend_q[cur_lvl] && (int'(cur_lvl) > GDIS_IDX));
endmodule

bind pend_return_ctrl pend_ret_chk #(.NLEV(NLEV), .GDIS_IDX(GDIS_IDX)) u_pend_ret_chk (.*);

// File: tb/test_pend_return_ctrl.sv
module test_pend_return_ctrl;
   localparam int NLEV = 16;
   localparam int LW   = 4;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            enter_vld = 1'b0;
   logic [LW-1:0]   enter_lvl = '0;
   logic            ret_vld = 1'b0;
   logic [1:0]      ret_kind = '0;
   logic            nest_en = 1'b0;
   logic            ret_addr_lsb = 1'b0;
   logic [NLEV-1:0] pend_q;
   logic [LW-1:0]   cur_lvl;
   logic            cur_vld;
   logic            gdis;
   logic            ret_err;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   typedef struct {
      logic [NLEV-1:0] pend;
      logic            err;
      string           tag;
   } exp_t;

   exp_t sb[$];
   logic [NLEV-1:0] model = '0;

   always #10 clk = ~clk;

   pend_return_ctrl i_pend_return_ctrl (.*);

   function automatic logic [NLEV-1:0] clear_low(logic [NLEV-1:0] v, int from);
      for (int k = from; k < NLEV; k++)
         if (v[k]) begin
            v[k] = 1'b0;
            return v;
         end
      return v;
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic step(bit r, bit ev, int lvl, bit rv, int kind, bit ne, bit lsb, string tag);
      exp_t e;
      @(negedge clk);
      rst = r; enter_vld = ev; enter_lvl = LW'(lvl); ret_vld = rv;
      ret_kind = 2'(kind); nest_en = ne; ret_addr_lsb = lsb;
      e.err = 1'b0;
      if (r) model = '0;
      else begin
         if (rv) begin
            if (model == '0) e.err = 1'b1;
            else if (kind == 0) begin
               model[4] = 1'b0;
               if (!(ne && lsb)) model = clear_low(model, 5);
            end else model = clear_low(model, 0);
         end
         if (ev) begin
            model[lvl] = 1'b1;
            model[4] = 1'b1;
         end
      end
      e.pend = model; e.tag = tag;
      sb.push_back(e);
   endtask

   initial begin : monitor
      exp_t e;
      int lv;
      bit vv;
      forever begin
         @(posedge clk);
         #5;
         if (sb.size() > 0) begin
            e = sb.pop_front();
            check(pend_q == e.pend, e.tag, "pend_q", int'(pend_q), int'(e.pend));
            check(ret_err == e.err, (e.err ? "R7" : e.tag), "ret_err", int'(ret_err), int'(e.err));
            check(gdis == e.pend[4], "R9", "gdis", int'(gdis), int'(e.pend[4]));
            lv = 0; vv = 0;
            for (int k = NLEV - 1; k >= 5; k--)
               if (e.pend[k]) begin lv = k; vv = 1; end
            check(cur_vld == vv && int'(cur_lvl) == lv, "R8", "cur_lvl", int'(cur_lvl), lv);
         end
      end
   end

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin : driver
      step(1, 1, 7, 1, 0, 0, 0, "R1");
      step(1, 0, 0, 0, 0, 0, 0, "R1");
      // R2: stack levels 12, 9, 6
      step(0, 1, 12, 0, 0, 1, 0, "R2");
      step(0, 1, 9, 0, 0, 1, 0, "R2");
      step(0, 1, 6, 0, 0, 1, 0, "R2");
      // R3: nested interrupt return keeps level 6
      step(0, 0, 0, 1, 0, 1, 1, "R3");
      step(0, 0, 0, 1, 0, 1, 1, "R3");
      // R4: lsb clear with nesting on drops level 6 and bit 4
      step(0, 1, 6, 0, 0, 1, 0, "R2");
      step(0, 0, 0, 1, 0, 1, 0, "R4");
      // R4: nesting off drops level 9
      step(0, 0, 0, 1, 0, 0, 1, "R4");
      // R6: interrupt return with re-entry of the same level
      step(0, 1, 12, 1, 0, 0, 0, "R6");
      // R5: exception-class returns clear lowest set bit
      step(0, 1, 2, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 1, 0, 0, "R5");
      step(0, 0, 0, 1, 2, 0, 0, "R5");
      step(0, 1, 3, 0, 0, 0, 0, "R2");
      step(0, 1, 0, 1, 3, 1, 1, "R6");
      step(0, 0, 0, 1, 3, 1, 1, "R5");
      step(0, 0, 0, 1, 1, 0, 0, "R5");
      step(0, 0, 0, 1, 2, 0, 0, "R5");
      // R4: interrupt return with only low bits set
      step(0, 1, 1, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 1, 0, 0, 0, "R4");
      step(0, 0, 0, 1, 1, 0, 0, "R5");
      // R7: returns on empty register
      step(0, 0, 0, 1, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 1, 2, 0, 0, "R7");
      step(0, 1, 15, 1, 1, 0, 0, "R7");
      step(0, 1, 5, 0, 0, 0, 0, "R2");
      step(0, 0, 0, 0, 0, 0, 0, "R8");
      step(1, 0, 0, 0, 0, 0, 0, "R1");
      step(0, 0, 0, 0, 0, 0, 0, "R1");
      repeat (3) @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule